// File: doc/BRIEF.md
# Reconfigurable Associativity Cache Controller

This block is a cache lookup and line-fill controller whose associativity can be changed while it runs. One fixed pool of eight physical storage banks serves as a direct-mapped cache, or as a 2-way, 4-way or 8-way set-associative cache. Total capacity is the same in every mode. A two-bit mode input selects the organisation. Each doubling of the way count moves one address bit out of the set index and into the compared tag. Only the banks that can hold the addressed set are enabled for an access. The other banks stay idle.

A processor-side port takes one 32-bit read or write per request and answers with a hit/miss flag and a data word. On a miss the controller reads the whole 64-byte block from a simple word-wide memory port in sixteen 4-byte beats. It places the block in a way of the addressed set, then completes the original access. Empty ways are filled first. When every way is occupied, a free-running 8-bit LFSR chooses the victim. Writes change only the cached copy. Changing the mode discards all cached lines in a single clear cycle.

Top module: `reconf_assoc_cache`

## Requirements
- R1: After reset, `req_ready_o` is 1 while `mode_i` is 0, and `resp_valid_o`, `busy_o`, `mem_req_o` and `bank_en_o` are all 0. The mode held at reset is direct-mapped.
- R2: A miss asserts `mem_req_o` for exactly 16 consecutive cycles. `mem_addr_o` starts at the block base (requested address with bits [5:0] cleared) and steps by 4. The response comes 18 cycles after the accepting edge with `resp_hit_o`=0, and its data is the memory word at the requested address (bits [1:0] ignored).
- R3: A read hit responds on the cycle after the accepting edge with `resp_hit_o`=1 and the cached word.
- R4: Mode encoding: 0 direct, 1 two-way, 2 four-way, 3 eight-way. With the default parameters the set index is address bits [11-m:6] and the compared tag is [28:12-m], where m is the mode value. Two blocks with equal index bits and different tags evict each other in direct mode and are both retained in 2-way mode.
- R5: A miss fills the lowest-numbered empty way of its set before any occupied way. N distinct blocks of one set in N-way mode are therefore all retained.
- R6: While `mode_i` differs from the active mode, `req_ready_o` is 0. The next edge starts a one-cycle clear with `busy_o`=1, and after it every line is invalid, so any later access misses.
- R7: Physical bank number = {group, way}, where the group is the low 3-m bits of address [11:9]. A lookup enables exactly the 2^m banks of the addressed group on `bank_en_o`. A fill enables exactly one bank.
- R8: A write hit updates the addressed word and responds the next cycle with `resp_hit_o`=1 and the written data. A write miss fills the block first, then writes, and responds with `resp_hit_o`=0 and the written data. Memory is never written, so a modified line that is evicted loses the write.
- R9: With all ways of a set valid, a miss replaces one way of that same set, chosen by the LFSR, and the new block hits on its next access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Requested mapping mode (0 direct, 1/2/3 = 2/4/8-way) |
| req_valid_i | input | 1 | Processor request present |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | 29 | Byte address |
| req_wdata_i | input | 32 | Write word |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| resp_valid_o | output | 1 | One-cycle response strobe |
| resp_hit_o | output | 1 | Response came from a hit |
| resp_rdata_o | output | 32 | Read word, or the written word for writes |
| busy_o | output | 1 | Mode-change clear in progress |
| bank_en_o | output | 8 | Per-bank access enable |
| mem_req_o | output | 1 | Fill beat request |
| mem_addr_o | output | 29 | Fill beat byte address |
| mem_rdata_i | input | 32 | Memory word for the current beat address, same cycle |

## Verification
The main mapping function is tried with four address patterns.

- **Sequential words of one block.** These separate the hit path from the fill path.
- **Two blocks that share index bits but differ in tag.** In direct mode they must evict each other; in 2-way mode they must coexist. This shows that the tag/index split follows the mode.
- **Eight blocks in one set in 8-way mode.** These expose any failure to prefer empty ways.
- **A ninth block in that set.** This forces a random replacement.

Addresses whose group bits differ show whether `bank_en_o` lights the correct banks in each mode. Write hits, write misses and a read after eviction show that writes are kept only in the cache.

// File: rtl/rac_pkg.sv
package rac_pkg;
  typedef enum logic [1:0] {
    MAP_DIRECT = 2'd0,
    MAP_2WAY   = 2'd1,
    MAP_4WAY   = 2'd2,
    MAP_8WAY   = 2'd3
  } map_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_FILL,
    ST_FINISH
  } ctl_state_e;
endpackage

// File: rtl/rac_lfsr.sv
module rac_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= {q[W-2:0], ^(q & TAPS)};
  end

  // R9: the replacement source never locks up at zero
  a_r9_lfsr_live: assert property (@(posedge clk) disable iff (rst) q != '0);
endmodule

// File: rtl/rac_bank.sv
module rac_bank #(
  parameter int DATA_W = 32,
  parameter int AW     = 7,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/rac_map_decode.sv
module rac_map_decode #(
  parameter int ADDR_W    = 29,
  parameter int OFF_W     = 6,
  parameter int BIDX_W    = 3,
  parameter int LOG_BANKS = 3,
  parameter int TAG_W     = 20,
  localparam int NBANK    = 1 << LOG_BANKS
) (
  input  logic [1:0]           mode,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NBANK-1:0]     grp_en,
  output logic [LOG_BANKS-1:0] way_mask,
  output logic [LOG_BANKS-1:0] bank_base,
  output logic [TAG_W-1:0]     tag_mask,
  output logic [TAG_W-1:0]     tag,
  output logic [BIDX_W-1:0]    bidx
);
  logic [LOG_BANKS-1:0] raw;

  assign tag  = addr[ADDR_W-1 -: TAG_W];
  assign bidx = addr[OFF_W +: BIDX_W];
  assign raw  = addr[OFF_W+BIDX_W +: LOG_BANKS];

  always_comb begin
    way_mask  = LOG_BANKS'((32'd1 << mode) - 32'd1);
    bank_base = raw << mode;
    tag_mask  = {TAG_W{1'b1}} << (LOG_BANKS - int'(mode));
    for (int b = 0; b < NBANK; b++)
      grp_en[b] = ((LOG_BANKS'(b) & ~way_mask) == bank_base);
  end
endmodule

// File: rtl/reconf_assoc_cache.sv
module reconf_assoc_cache
  import rac_pkg::*;
#(
  parameter int ADDR_W     = 29,
  parameter int DATA_W     = 32,
  parameter int OFF_W      = 6,
  parameter int LINE_IDX_W = 6,
  parameter int LOG_BANKS  = 3,
  parameter int LFSR_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              busy_o,
  output logic [(1<<LOG_BANKS)-1:0] bank_en_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int NBANK  = 1 << LOG_BANKS;
  localparam int NLINE  = 1 << LINE_IDX_W;
  localparam int BIDX_W = LINE_IDX_W - LOG_BANKS;
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WORD_W = OFF_W - BYTE_W;
  localparam int BEATS  = 1 << WORD_W;
  localparam int TAG_W  = ADDR_W - OFF_W - BIDX_W;

  ctl_state_e            state_q;
  logic [1:0]            mode_q;
  logic [NLINE-1:0]      valid_q;
  logic [TAG_W-1:0]      tag_q [NLINE];
  logic [ADDR_W-1:0]     addr_q;
  logic                  write_q;
  logic [DATA_W-1:0]     wdata_q;
  logic [LOG_BANKS-1:0]  victim_q, sel_q;
  logic [WORD_W-1:0]     beat_q;
  logic                  resp_valid_q, resp_hit_q, resp_wr_q;

  logic [NBANK-1:0]      grp_en, hit_vec, inv_vec;
  logic [LOG_BANKS-1:0]  way_mask, bank_base, hit_bank, inv_bank, victim_d;
  logic [TAG_W-1:0]      tag_mask, req_tag;
  logic [BIDX_W-1:0]     req_bidx, bidx_q;
  logic [WORD_W-1:0]     word_q;
  logic [LFSR_W-1:0]     lfsr;
  logic                  accept, fill_last;

  logic [NBANK-1:0]             bank_en, bank_we;
  logic [BIDX_W+WORD_W-1:0]     bank_addr;
  logic [DATA_W-1:0]            bank_wdata;
  logic [DATA_W-1:0]            bank_rd [NBANK];

  rac_map_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BIDX_W(BIDX_W),
    .LOG_BANKS(LOG_BANKS), .TAG_W(TAG_W)
  ) u_decode (
    .mode(mode_q), .addr(req_addr_i), .grp_en(grp_en), .way_mask(way_mask),
    .bank_base(bank_base), .tag_mask(tag_mask), .tag(req_tag), .bidx(req_bidx)
  );

  rac_lfsr #(.W(LFSR_W)) u_lfsr (.clk(clk), .rst(rst), .q(lfsr));

  assign bidx_q    = addr_q[OFF_W +: BIDX_W];
  assign word_q    = addr_q[BYTE_W +: WORD_W];
  assign fill_last = (beat_q == WORD_W'(BEATS - 1));
  assign req_ready_o = (state_q == ST_IDLE) && (mode_i == mode_q);
  assign accept    = req_valid_i && req_ready_o;

  // Tag compare across the addressed group, empty-way search, victim pick
  always_comb begin
    logic [LINE_IDX_W-1:0] lidx;
    hit_vec  = '0;
    inv_vec  = '0;
    hit_bank = '0;
    inv_bank = '0;
    for (int b = 0; b < NBANK; b++) begin
      lidx       = {LOG_BANKS'(b), req_bidx};
      hit_vec[b] = grp_en[b] && valid_q[lidx] && (((tag_q[lidx] ^ req_tag) & tag_mask) == '0);
      inv_vec[b] = grp_en[b] && !valid_q[lidx];
    end
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (hit_vec[b]) hit_bank = LOG_BANKS'(b);
      if (inv_vec[b]) inv_bank = LOG_BANKS'(b);
    end
    victim_d = (|inv_vec) ? inv_bank : (bank_base | (lfsr[LOG_BANKS-1:0] & way_mask));
  end

  // Bank port steering; idle banks keep enable low
  always_comb begin
    bank_en    = '0;
    bank_we    = '0;
    bank_addr  = {req_bidx, req_addr_i[BYTE_W +: WORD_W]};
    bank_wdata = req_wdata_i;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        bank_en = grp_en;
        bank_we = req_write_i ? hit_vec : '0;
      end
      ST_FILL: begin
        bank_en[victim_q] = 1'b1;
        bank_we[victim_q] = 1'b1;
        bank_addr         = {bidx_q, beat_q};
        bank_wdata        = mem_rdata_i;
      end
      ST_FINISH: begin
        bank_en[victim_q] = 1'b1;
        bank_we[victim_q] = write_q;
        bank_addr         = {bidx_q, word_q};
        bank_wdata        = wdata_q;
      end
      default: ;
    endcase
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rac_bank #(.DATA_W(DATA_W), .AW(BIDX_W + WORD_W)) u_bank (
      .clk(clk), .en(bank_en[b]), .we(bank_we[b]), .addr(bank_addr),
      .wdata(bank_wdata), .rdata(bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      mode_q       <= MAP_DIRECT;
      valid_q      <= '0;
      addr_q       <= '0;
      write_q      <= 1'b0;
      wdata_q      <= '0;
      victim_q     <= '0;
      sel_q        <= '0;
      beat_q       <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_wr_q    <= 1'b0;
    end else begin
      resp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (mode_i != mode_q) begin
            mode_q  <= mode_i;
            state_q <= ST_CLEAR;
          end else if (req_valid_i) begin
            addr_q    <= req_addr_i;
            write_q   <= req_write_i;
            wdata_q   <= req_wdata_i;
            resp_wr_q <= req_write_i;
            if (|hit_vec) begin
              resp_valid_q <= 1'b1;
              resp_hit_q   <= 1'b1;
              sel_q        <= hit_bank;
            end else begin
              victim_q <= victim_d;
              beat_q   <= '0;
              state_q  <= ST_FILL;
            end
          end
        end
        ST_CLEAR: begin
          valid_q <= '0;
          state_q <= ST_IDLE;
        end
        ST_FILL: begin
          beat_q <= beat_q + WORD_W'(1);
          if (fill_last) begin
            valid_q[{victim_q, bidx_q}] <= 1'b1;
            state_q <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          resp_valid_q <= 1'b1;
          resp_hit_q   <= 1'b0;
          sel_q        <= victim_q;
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_FILL && fill_last)
      tag_q[{victim_q, bidx_q}] <= addr_q[ADDR_W-1 -: TAG_W];
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_hit_o   = resp_hit_q;
  assign resp_rdata_o = resp_wr_q ? wdata_q : bank_rd[sel_q];
  assign busy_o       = (state_q == ST_CLEAR);
  assign bank_en_o    = bank_en;
  assign mem_req_o    = (state_q == ST_FILL);
  assign mem_addr_o   = {addr_q[ADDR_W-1:OFF_W], beat_q, {BYTE_W{1'b0}}};

  logic unused_bits;
  assign unused_bits = ^{req_addr_i[BYTE_W-1:0], lfsr[LFSR_W-1:LOG_BANKS]};

  // R6: no request is taken while the clear runs, and the clear empties every line
  a_r6_busy_blocks_req: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !req_ready_o);
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (valid_q == '0));
  // R7: never more banks active than the mode has ways
  a_r7_bank_limit: assert property (@(posedge clk) disable iff (rst)
    $countones(bank_en_o) <= (1 << mode_q));
  // R9: a fill writes into a single bank
  a_r9_fill_one_bank: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> ($countones(bank_en_o) == 1));
  // R2: fill beats walk the block in word steps with ready held low
  a_r2_beat_step: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && $past(mem_req_o)) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(DATA_W / 8)));
  a_r2_fill_not_ready: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> !req_ready_o);
  // R3: a hit response follows an accepted request
  a_r3_hit_follows_accept: assert property (@(posedge clk) disable iff (rst)
    (resp_valid_o && resp_hit_o) |-> $past(req_valid_i && req_ready_o));
endmodule

// File: tb/reconf_assoc_cache_tb.sv
module reconf_assoc_cache_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  mode;
  logic        req_valid, req_write;
  logic [28:0] req_addr;
  logic [31:0] req_wdata;
  logic        req_ready, resp_valid, resp_hit, busy, mem_req;
  logic [31:0] resp_rdata, mem_rdata;
  logic [7:0]  bank_en;
  logic [28:0] mem_addr;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  // Memory model: word at byte address a reads as a with bits [1:0] set
  assign mem_rdata = {3'b0, mem_addr[28:2], 2'b11};

  reconf_assoc_cache u_dut (
    .clk(clk), .rst(rst), .mode_i(mode), .req_valid_i(req_valid),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_ready_o(req_ready), .resp_valid_o(resp_valid), .resp_hit_o(resp_hit),
    .resp_rdata_o(resp_rdata), .busy_o(busy), .bank_en_o(bank_en),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata)
  );

  // {write, addr, wdata, expect_hit, expect_data}; direct-mapped mode
  localparam logic [94:0] VEC [10] = '{
    {1'b0, 29'h0010040, 32'h0,        1'b0, 32'h00010043},
    {1'b0, 29'h0010044, 32'h0,        1'b1, 32'h00010047},
    {1'b1, 29'h0010048, 32'hDEADBEEF, 1'b1, 32'hDEADBEEF},
    {1'b0, 29'h0010048, 32'h0,        1'b1, 32'hDEADBEEF},
    {1'b0, 29'h0020040, 32'h0,        1'b0, 32'h00020043},
    {1'b0, 29'h0010040, 32'h0,        1'b0, 32'h00010043},
    {1'b0, 29'h0010048, 32'h0,        1'b1, 32'h0001004B},
    {1'b1, 29'h0030080, 32'h12345678, 1'b0, 32'h12345678},
    {1'b0, 29'h0030080, 32'h0,        1'b1, 32'h12345678},
    {1'b0, 29'h0030084, 32'h0,        1'b1, 32'h00030087}
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic        r_hit;
  logic [31:0] r_data;
  int          r_lat, r_beats;
  logic        r_beats_ok;
  logic [7:0]  r_ben;

  task automatic access(input logic wr, input logic [28:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    r_ben = bank_en;
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 1; r_beats = 0; r_beats_ok = 1'b1;
    while (!resp_valid && r_lat < 100) begin
      if (mem_req) begin
        if (mem_addr !== ({a[28:6], 6'b0} + 29'(r_beats * 4))) r_beats_ok = 1'b0;
        r_beats++;
      end
      @(negedge clk);
      r_lat++;
    end
    r_hit  = resp_hit;
    r_data = resp_rdata;
  endtask

  task automatic expect_miss(input string req, input logic [28:0] a, input logic [31:0] exp_d);
    access(1'b0, a, 32'h0);
    chk(req, "miss flag", r_hit, 1'b0);
    chk(req, "miss data", r_data, exp_d);
    chk("R2", "miss latency", r_lat, 18);
  endtask

  task automatic expect_hit(input string req, input logic [28:0] a, input logic [31:0] exp_d);
    access(1'b0, a, 32'h0);
    chk(req, "hit flag", r_hit, 1'b1);
    chk(req, "hit data", r_data, exp_d);
    chk("R3", "hit latency", r_lat, 1);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
    #1 chk("R6", "ready while mode differs", req_ready, 1'b0);
    @(negedge clk);
    chk("R6", "busy during clear", busy, 1'b1);
    chk("R6", "ready during clear", req_ready, 1'b0);
    @(negedge clk);
    chk("R6", "busy after clear", busy, 1'b0);
    chk("R6", "ready after clear", req_ready, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; mode = 2'd0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ready", req_ready, 1'b1);
    chk("R1", "resp_valid", resp_valid, 1'b0);
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "mem_req", mem_req, 1'b0);
    chk("R1", "bank_en", bank_en, 8'h00);

    // Vector table in direct mode: R2 R3 R4 R7 R8
    for (int i = 0; i < 10; i++) begin
      logic [94:0] e;
      e = VEC[i];
      access(e[94], e[93:65], e[64:33]);
      chk(e[94] ? "R8" : "R4", "table hit flag", r_hit, e[32]);
      chk(e[94] ? "R8" : "R3", "table data", r_data, e[31:0]);
      chk("R7", "direct bank enable", r_ben, 8'h01);
      if (e[32]) chk("R3", "table hit latency", r_lat, 1);
      else begin
        chk("R2", "table miss latency", r_lat, 18);
        chk("R2", "beat count", r_beats, 16);
        chk("R2", "beat addresses", r_beats_ok, 1'b1);
      end
    end

    access(1'b0, 29'h0010240, 32'h0);
    chk("R7", "direct group 1 enable", r_ben, 8'h02);
    chk("R2", "group 1 miss flag", r_hit, 1'b0);

    // Two-way: clear, then coexisting tags
    set_mode(2'd1);
    expect_miss("R6", 29'h0030080, 32'h00030083);
    chk("R7", "2-way group 0 enable", r_ben, 8'h03);
    expect_miss("R4", 29'h0010040, 32'h00010043);
    expect_miss("R4", 29'h0020040, 32'h00020043);
    expect_hit("R5", 29'h0010040, 32'h00010043);
    expect_hit("R5", 29'h0020040, 32'h00020043);
    expect_miss("R9", 29'h0030040, 32'h00030043);
    expect_hit("R9", 29'h0030040, 32'h00030043);
    expect_miss("R7", 29'h0010640, 32'h00010643);
    chk("R7", "2-way group 3 enable", r_ben, 8'hC0);

    // Eight-way: eight blocks of one set fill empty ways, a ninth replaces
    set_mode(2'd3);
    for (int k = 0; k < 8; k++)
      expect_miss("R5", 29'(k * 512 + 64), 32'(k * 512 + 67));
    for (int k = 0; k < 8; k++) begin
      expect_hit("R5", 29'(k * 512 + 64), 32'(k * 512 + 67));
      chk("R7", "8-way enable", r_ben, 8'hFF);
    end
    expect_miss("R9", 29'h0001040, 32'h00001043);
    expect_hit("R9", 29'h0001040, 32'h00001043);

    // Four-way: group from bit 9
    set_mode(2'd2);
    expect_miss("R7", 29'h0010240, 32'h00010243);
    chk("R7", "4-way group 1 enable", r_ben, 8'hF0);
    access(1'b1, 29'h0010244, 32'hCAFE0001);
    chk("R8", "4-way write hit flag", r_hit, 1'b1);
    chk("R8", "4-way write echo", r_data, 32'hCAFE0001);
    expect_hit("R8", 29'h0010244, 32'hCAFE0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule